// File: doc/BRIEF.md
# Reset and wake-up sequencer

This block decides when the rest of a small microcontroller may leave reset and when its core clock may run. Two sources can demand a reset: an active-low external pin and a watchdog request. The pin passes through a synchronizer and a digital glitch filter, so short spikes on the board do not restart the chip. The watchdog request may be a single-cycle pulse and is latched.

After a reset request goes away, the internal reset is held until four things are all true. The pin is released, the oscillator reports that it is running, a wake-up timer has counted a fixed number of clocks, and the flash controller reports that its initialization is done. Release then enables the core clock and produces a one-cycle strobe that tells the core to fetch from address 0.

When software requests power-down, the core clock stops and reset stays deasserted. Any of the external wake lines brings the core back. The wake lines are level-sensitive and pass through a two-flop synchronizer. The path back goes through the same oscillator wait, wake-up timer and flash check as a reset, but without asserting reset and without the address-0 fetch strobe.

Top module: `rst_wake_seq`

## Requirements
- R1: While `por_ni` is low, `sys_rst_o` is 1, `clk_en_o` is 0 and `vec_fetch_o` is 0.
- R2: A low pulse on `rst_pin_ni` lasting fewer than `FILT_CYC` clock cycles never asserts `sys_rst_o`. A low pulse of `FILT_CYC` cycles or longer asserts it.
- R3: A single-cycle high pulse on `wdt_rst_i` in normal operation asserts `sys_rst_o` two cycles later. With the oscillator and flash ready, the core runs again `WK_TERM`+6 cycles after the pulse, and a fetch strobe is issued.
- R4: `sys_rst_o` stays asserted for as long as `osc_ok_i` is low, whatever the other inputs do.
- R5: With the pin released and flash ready, `sys_rst_o` falls exactly `WK_TERM`+2 cycles after `osc_ok_i` rises.
- R6: If `osc_ok_i` drops while the wake-up timer is counting, the count restarts from zero. Release then comes `WK_TERM`+2 cycles after the oscillator flag returns.
- R7: `sys_rst_o` stays asserted while `flash_ready_i` is low. Once the timer has expired, it falls one cycle after `flash_ready_i` rises.
- R8: `vec_fetch_o` is high for exactly one cycle, the first cycle in which `clk_en_o` is high after a reset release. It never pulses on resume from power-down.
- R9: A high `pd_req_i` while running clears `clk_en_o` on the next cycle and keeps `sys_rst_o` low. With no wake line high, the block stays in power-down.
- R10: A wake line held high in power-down restarts the core clock after the oscillator wait and the full wake-up timer, without asserting `sys_rst_o`. With the oscillator already running, `clk_en_o` rises `WK_TERM`+5 cycles after the wake line rises.
- R11: After a long pin reset, `clk_en_o` rises `FILT_CYC`+`WK_TERM`+5 cycles after `rst_pin_ni` returns high, provided the oscillator and flash are ready.
- R12: `clk_en_o` is never high while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running sequencer clock |
| por_ni | input | 1 | Power-on reset of the sequencer itself, active low, asynchronous |
| rst_pin_ni | input | 1 | Raw external reset pin, active low, asynchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, may be a one-cycle pulse |
| osc_ok_i | input | 1 | Oscillator running flag |
| flash_ready_i | input | 1 | Flash controller initialization complete |
| pd_req_i | input | 1 | Power-down request from the core |
| wake_i | input | N_WAKE | External wake lines, active high, asynchronous |
| sys_rst_o | output | 1 | Internal chip reset, active high |
| clk_en_o | output | 1 | Core clock enable |
| vec_fetch_o | output | 1 | One-cycle strobe to fetch the reset vector at address 0 |

## Verification
A wrong sequencer state shows directly at the three outputs. A state that skips or repeats timer cycles moves the release edge by that many cycles. This is why release and resume latencies are measured to the exact cycle against values derived from `FILT_CYC` and `WK_TERM`. A lost watchdog latch or a leaking glitch filter shows within a few cycles as a missing or spurious `sys_rst_o`. A wrong warm-resume flag shows as a reset pulse or a fetch strobe during a power-down exit, which the bench counts over the whole wake window.

// File: rtl/rwk_pkg.sv
package rwk_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_WOSC   = 3'd1,
    ST_COUNT  = 3'd2,
    ST_WFLASH = 3'd3,
    ST_RUN    = 3'd4,
    ST_PDOWN  = 3'd5
  } rwk_state_e;
endpackage

// File: rtl/rwk_sync2.sv
module rwk_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rwk_pin_filter.sv
module rwk_pin_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic          pin_s;
  logic          filt_q, filt_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          want;

  rwk_sync2 #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  assign want = ~pin_s;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (want != filt_q) begin
      if (cnt_q == FW'(FILT_CYC - 1)) begin
        filt_d = want;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o = filt_q;
endmodule

// File: rtl/rwk_wake_timer.sv
module rwk_wake_timer #(
  parameter int CNT_W = 6,
  parameter int TERM  = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(TERM - 1));
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq #(
  parameter int FILT_CYC = 4,
  parameter int WK_CNT_W = 6,
  parameter int WK_TERM  = 24,
  parameter int N_WAKE   = 3
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_pin_ni,
  input  logic              wdt_rst_i,
  input  logic              osc_ok_i,
  input  logic              flash_ready_i,
  input  logic              pd_req_i,
  input  logic [N_WAKE-1:0] wake_i,
  output logic              sys_rst_o,
  output logic              clk_en_o,
  output logic              vec_fetch_o
);
  import rwk_pkg::*;

  rwk_state_e  state_q, state_d;
  logic        pin_req;
  logic        wdt_q, wdt_d;
  logic        warm_q, warm_d;
  logic        vec_q, vec_d;
  logic        tmr_done;
  logic [N_WAKE-1:0] wake_s;
  logic        rst_req;

  rwk_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .pin_ni(rst_pin_ni),
    .req_o (pin_req)
  );

  rwk_sync2 #(.W(N_WAKE), .RST_VAL('0)) u_wsync (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .d_i   (wake_i),
    .q_o   (wake_s)
  );

  rwk_wake_timer #(.CNT_W(WK_CNT_W), .TERM(WK_TERM)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .run_i (state_q == ST_COUNT),
    .done_o(tmr_done)
  );

  assign rst_req = pin_req | wdt_q;

  // watchdog latch: held until consumed by the hold state
  always_comb begin
    wdt_d = wdt_rst_i | (wdt_q & (state_q != ST_HOLD));
  end

  always_comb begin
    state_d = state_q;
    if (rst_req) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:   state_d = ST_WOSC;
        ST_WOSC:   if (osc_ok_i) state_d = ST_COUNT;
        ST_COUNT:  if (!osc_ok_i) state_d = ST_WOSC;
                   else if (tmr_done) state_d = ST_WFLASH;
        ST_WFLASH: if (!osc_ok_i) state_d = ST_WOSC;
                   else if (flash_ready_i) state_d = ST_RUN;
        ST_RUN:    if (pd_req_i) state_d = ST_PDOWN;
        ST_PDOWN:  if (|wake_s) state_d = ST_WOSC;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  always_comb begin
    warm_d = warm_q;
    if (state_d == ST_HOLD)                           warm_d = 1'b0;
    else if (state_q == ST_RUN && state_d == ST_PDOWN) warm_d = 1'b1;
    vec_d = (state_q == ST_WFLASH) && (state_d == ST_RUN) && !warm_q;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      state_q <= ST_HOLD;
      wdt_q   <= 1'b0;
      warm_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wdt_q   <= wdt_d;
      warm_q  <= warm_d;
      vec_q   <= vec_d;
    end
  end

  assign clk_en_o    = (state_q == ST_RUN);
  assign sys_rst_o   = !((state_q == ST_RUN) || (state_q == ST_PDOWN) || warm_q);
  assign vec_fetch_o = vec_q;
endmodule

// File: rtl/rwk_chk.sv
module rwk_chk (
  input logic clk,
  input logic rst_n,
  input logic wdt,
  input logic osc,
  input logic flash,
  input logic sys_rst,
  input logic clk_en,
  input logic vec
);
  // R3
  wdt_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt |-> ##2 sys_rst);

  // R7
  release_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> ($past(flash) && $past(osc)));

  // R4
  clk_on_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(osc));

  // R8
  vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec |=> !vec);

  // R8
  vec_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec |-> (clk_en && !sys_rst));

  // R12
  en_excl_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> !sys_rst);
endmodule

bind rst_wake_seq rwk_chk u_chk (
  .clk    (clk_i),
  .rst_n  (por_ni),
  .wdt    (wdt_rst_i),
  .osc    (osc_ok_i),
  .flash  (flash_ready_i),
  .sys_rst(sys_rst_o),
  .clk_en (clk_en_o),
  .vec    (vec_fetch_o)
);

// File: tb/rst_wake_seq_bench.sv
module rst_wake_seq_bench;
  localparam int FILT = 4;
  localparam int TERM = 24;
  localparam int NW   = 3;

  logic clk, por_n, pin_n, wdt, osc, flash, pd;
  logic [NW-1:0] wake;
  logic sys_rst, clk_en, vec;
  int tests, fails;

  rst_wake_seq #(.FILT_CYC(FILT), .WK_CNT_W(6), .WK_TERM(TERM), .N_WAKE(NW)) u_rst_wake_seq (
    .clk_i(clk), .por_ni(por_n), .rst_pin_ni(pin_n), .wdt_rst_i(wdt),
    .osc_ok_i(osc), .flash_ready_i(flash), .pd_req_i(pd), .wake_i(wake),
    .sys_rst_o(sys_rst), .clk_en_o(clk_en), .vec_fetch_o(vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lat_osc();   return TERM + 2;        endfunction
  function automatic int lat_wake();  return TERM + 5;        endfunction
  function automatic int lat_wdt();   return TERM + 6;        endfunction
  function automatic int lat_pin();   return FILT + TERM + 5; endfunction
  function automatic bit rejected(int len); return len < FILT; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic watch(input int n, output int rst_hi, output int en_hi, output int vec_n);
    rst_hi = 0; en_hi = 0; vec_n = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      rst_hi += int'(sys_rst); en_hi += int'(clk_en); vec_n += int'(vec);
    end
  endtask

  task automatic to_run(output int n, output int vec_n, output int rst_hi);
    n = 0; vec_n = 0; rst_hi = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++; vec_n += int'(vec); rst_hi += int'(sys_rst);
    end while (!(clk_en && !sys_rst) && n < 2000);
  endtask

  task automatic pin_pulse(input int len);
    pin_n = 1'b0;
    repeat (len) @(negedge clk);
    pin_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  initial begin
    int n, v, r, e, seed_val;
    seed_val = $urandom(32'h5eed_0042);
    tests = 0; fails = 0;
    por_n = 0; pin_n = 1; wdt = 0; osc = 0; flash = 0; pd = 0; wake = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sys_rst == 1'b1, "R1 sys_rst", int'(sys_rst), 1);
    chk(clk_en == 1'b0, "R1 clk_en", int'(clk_en), 0);
    chk(vec == 1'b0, "R1 vec_fetch", int'(vec), 0);
    por_n = 1;

    // R4: oscillator not running keeps reset
    watch(40, r, e, v);
    chk(r == 40, "R4 reset held without osc", r, 40);
    // R7: flash not ready keeps reset after timer
    osc = 1;
    watch(TERM + 20, r, e, v);
    chk(r == TERM + 20 && e == 0, "R7 reset held without flash", r, TERM + 20);
    flash = 1;
    to_run(n, v, r);
    chk(n == 1, "R7 release after flash ready", n, 1);
    chk(v == 1, "R8 fetch strobe on release", v, 1);
    watch(5, r, e, v);
    chk(v == 0, "R8 strobe is one cycle", v, 0);

    // R11: long pin reset and release latency
    pin_n = 0;
    watch(20, r, e, v);
    chk(r > 0 && sys_rst, "R2 long pin pulse asserts reset", r, 1);
    pin_n = 1;
    to_run(n, v, r);
    chk(n == lat_pin(), "R11 pin release latency", n, lat_pin());
    chk(v == 1, "R8 strobe after pin reset", v, 1);

    // R5: timer length measured from oscillator rise
    osc = 0; pin_n = 0;
    repeat (20) @(negedge clk);
    pin_n = 1;
    repeat (FILT + 10) @(negedge clk);
    osc = 1;
    to_run(n, v, r);
    chk(n == lat_osc(), "R5 wake timer length", n, lat_osc());

    // R6: oscillator drop restarts count
    osc = 0; pin_n = 0;
    repeat (20) @(negedge clk);
    pin_n = 1;
    repeat (FILT + 10) @(negedge clk);
    osc = 1;
    repeat (TERM / 2) @(negedge clk);
    osc = 0;
    @(negedge clk);
    osc = 1;
    to_run(n, v, r);
    chk(n == lat_osc(), "R6 count restart after osc drop", n, lat_osc());

    // R3: single-cycle watchdog pulse
    repeat (3) @(negedge clk);
    wdt = 1;
    @(negedge clk);
    wdt = 0;
    @(negedge clk);
    chk(sys_rst == 1'b1, "R3 watchdog asserts reset", int'(sys_rst), 1);
    to_run(n, v, r);
    chk(n + 2 == lat_wdt(), "R3 watchdog recovery latency", n + 2, lat_wdt());
    chk(v == 1, "R3 strobe after watchdog reset", v, 1);

    // R2: random short glitches, then directed boundaries
    for (int k = 0; k < 25; k++) begin
      int len;
      len = 1 + int'($urandom % (FILT - 1));
      pin_pulse(len);
      watch(3 * FILT + 6, r, e, v);
      chk(rejected(len) && r == 0, "R2 short glitch rejected", r, 0);
    end
    pin_pulse(FILT - 1);
    watch(3 * FILT + 6, r, e, v);
    chk(r == 0, "R2 pulse of FILT-1 rejected", r, 0);
    pin_pulse(FILT);
    watch(3 * FILT + 6, r, e, v);
    chk(r > 0, "R2 pulse of FILT accepted", r, 1);
    to_run(n, v, r);

    // R9: power-down without wake
    pd = 1;
    @(negedge clk);
    pd = 0;
    chk(clk_en == 1'b0 && sys_rst == 1'b0, "R9 enter power-down", int'(clk_en), 0);
    watch(50, r, e, v);
    chk(r == 0 && e == 0, "R9 stays down without wake", e, 0);

    // R10: wake with oscillator stopped
    osc = 0;
    wake[1] = 1'b1;
    watch(30, r, e, v);
    chk(e == 0 && r == 0, "R10 waits for osc on wake", e, 0);
    osc = 1;
    to_run(n, v, r);
    chk(n == lat_osc(), "R10 resume latency from osc", n, lat_osc());
    chk(v == 0 && r == 0, "R8 no strobe or reset on resume", v + r, 0);
    wake = '0;

    // R10: random wake line with oscillator running
    for (int k = 0; k < 4; k++) begin
      int j;
      repeat (3) @(negedge clk);
      pd = 1;
      @(negedge clk);
      pd = 0;
      repeat (5 + int'($urandom % 16)) @(negedge clk);
      j = int'($urandom % NW);
      wake[j] = 1'b1;
      to_run(n, v, r);
      chk(n == lat_wake(), "R10 resume latency from wake", n, lat_wake());
      chk(v == 0 && r == 0, "R10 warm resume keeps reset low", v + r, 0);
      wake = '0;
    end
    watch(5, r, e, v);
    chk(e == 5 && r == 0, "R12 running after resume", e, 5);

    summary();
  end
endmodule